// File: doc/BRIEF.md
# Flash Status Register with Block Protection

This block holds the status byte of a serial flash memory and decides whether a write to the array may go ahead. The byte carries an operation-in-progress flag, the write-enable latch, an auto-increment programming flag, four protection-level bits and a protection lock bit. The block receives instruction events that a serial front end has already decoded, together with the frame-end strobe (chip-select rising), the active-low write-protect pin, and start and completion pulses from the array engine.

Status writes need two steps. An arming instruction (50h or 06h) must be the instruction directly before the status write (01h). The new byte is then applied when the frame ends. A lock bit, together with a low write-protect pin, can freeze the protection settings. The protection level marks an upper slice of the array as protected. The block compares a requested address against that slice, or checks a chip-erase request, and produces a permit signal that the array engine uses to accept or drop the operation.

Top module: `sr_protect`

## Requirements
- R1: After reset the status byte reads 1Ch. Bit 0 is busy, bit 1 is the write-enable latch, bits 5:2 are the protect field P3..P0, bit 6 is the auto-increment flag and bit 7 is the lock bit. After reset P2..P0 are 1 and every other bit is 0.
- R2: Opcode 06h sets bit 1. Opcode 04h clears bit 1 and bit 6.
- R3: A status write (opcode 01h) is accepted only when the instruction directly before it was 50h or 06h. Any other instruction in between cancels the arming, and an unarmed write leaves the byte unchanged.
- R4: An accepted status write takes effect on the cs_rise pulse that follows its data byte. Bits 7 and 5:2 are loaded from the data byte. Bits 0 and 6 are not taken from the data byte, and bit 1 is cleared.
- R5: When wp_n is low and bit 7 is 1, a status write changes nothing in bits 7 and 5:2. When wp_n is low and bit 7 is 0, one write can set bit 7 and change the protect field together. When wp_n is high, bit 7 has no effect.
- R6: For a program or sector/block request (req_chip=0), permit is low when req_addr falls in the protected slice. Based on P2..P0, that slice is: 000 none, 001 the top 1/32, 010 the top 1/16, 011 the top 1/8, 100 the top 1/4, 101 the top 1/2, and 11x the whole array. P3 does not affect this slice.
- R7: For a chip-erase request (req_chip=1), permit is high only when all four protect bits are 0.
- R8: op_start sets busy and aai_start sets bit 6. op_done clears busy and also clears bit 1 when bit 6 is 0. When bit 6 is 1, op_done keeps bit 1.
- R9: While busy is 1, opcodes 06h and 04h and status writes change nothing. The byte stays readable during this time.
- R10: A cs_rise pulse that arrives before the data byte of a status write cancels that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Pulse: a decoded opcode is present |
| op_code | input | 8 | Opcode byte |
| data_valid | input | 1 | Pulse: a data byte following the opcode is present |
| data_byte | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip select went high (frame end) |
| wp_n | input | 1 | Write-protect pin, active low |
| op_start | input | 1 | Pulse: array engine started a program/erase |
| aai_start | input | 1 | Pulse: auto-increment programming entered |
| op_done | input | 1 | Pulse: array operation complete |
| req_addr | input | ADDR_W | Address of the requested write |
| req_chip | input | 1 | Request is a chip erase |
| status | output | 8 | Status byte |
| permit | output | 1 | Requested operation allowed |

## Verification
Every status-byte result is due one clock after the edge that samples the causing pulse. The bench drives each pulse on a falling edge and clears it on the next falling edge, and the state has been updated by then, so it reads the byte at that falling edge. The permit output is combinational from the stored protect field and the request inputs. For each table row the bench first completes the status write that sets the field, then changes the address and samples permit a nanosecond later, inside the same low clock phase.

// File: rtl/sr_protect.sv
module sr_protect #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  input  logic              cs_rise,
  input  logic              wp_n,
  input  logic              op_start,
  input  logic              aai_start,
  input  logic              op_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_chip,
  output logic [7:0]        status,
  output logic              permit
);
  localparam logic [7:0] OP_ARM = 8'h50;
  localparam logic [7:0] OP_WEN = 8'h06;
  localparam logic [7:0] OP_WDS = 8'h04;
  localparam logic [7:0] OP_SWR = 8'h01;
  localparam int         LEVELS = 5;

  logic       busy, wel, aai, lock;
  logic [3:0] prot;
  logic       armed, pend, got_data;
  logic [7:0] new_byte;

  wire frozen = !wp_n && lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wel      <= 1'b0;
      aai      <= 1'b0;
      lock     <= 1'b0;
      prot     <= 4'b0111;
      armed    <= 1'b0;
      pend     <= 1'b0;
      got_data <= 1'b0;
      new_byte <= 8'h00;
    end else begin
      if (op_start)  busy <= 1'b1;
      if (aai_start) aai  <= 1'b1;
      if (op_done) begin
        busy <= 1'b0;
        if (!aai) wel <= 1'b0;
      end
      if (op_valid) begin
        armed    <= !busy && (op_code == OP_ARM || op_code == OP_WEN);
        pend     <= !busy && armed && op_code == OP_SWR;
        got_data <= 1'b0;
        if (!busy && op_code == OP_WEN) wel <= 1'b1;
        if (!busy && op_code == OP_WDS) begin
          wel <= 1'b0;
          aai <= 1'b0;
        end
      end
      if (data_valid && pend && !got_data) begin
        new_byte <= data_byte;
        got_data <= 1'b1;
      end
      if (cs_rise) begin
        pend     <= 1'b0;
        got_data <= 1'b0;
        if (pend && got_data && !busy) begin
          wel <= 1'b0;
          if (!frozen) begin
            lock <= new_byte[7];
            prot <= new_byte[5:2];
          end
        end
      end
    end
  end

  assign status = {lock, aai, prot, wel, busy};

  logic [LEVELS:1] top_hit;
  for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
    assign top_hit[k] = &req_addr[ADDR_W-1 -: (LEVELS + 1 - k)];
  end

  logic in_prot;
  always_comb begin
    case (prot[2:0])
      3'd0:       in_prot = 1'b0;
      3'd6, 3'd7: in_prot = 1'b1;
      default:    in_prot = top_hit[prot[2:0]];
    endcase
  end

  assign permit = req_chip ? (prot == 4'd0) : !in_prot;
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [7:0]        op_code,
  input logic              cs_rise,
  input logic              wp_n,
  input logic              op_start,
  input logic              op_done,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_chip,
  input logic [7:0]        status,
  input logic              permit
);
  p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 8'h06 && !status[0] && !cs_rise) |=> status[1]);

  p_ro_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !op_start && !op_done) |=> $stable(status[0]));

  p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status[7]) |=> ($stable(status[7]) && $stable(status[5:2])));

  p_chip_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_chip && permit) |-> (status[5:2] == 4'd0));

  p_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> status[0]);

  p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !op_done) |=> ($stable(status[7]) && $stable(status[5:1])));
endmodule

bind sr_protect sr_protect_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sr_protect_bench.sv
module sr_protect_bench;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0, data_valid = 1'b0, cs_rise = 1'b0;
  logic [7:0]    op_code = 8'h00, data_byte = 8'h00;
  logic          wp_n = 1'b1, op_start = 1'b0, aai_start = 1'b0, op_done = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_chip = 1'b0;
  logic [7:0]    status;
  logic          permit;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  sr_protect #(.ADDR_W(AW)) u_sr_protect (.*);

  // {prot[3:0], addr[20:0], chip, expected permit}
  localparam int NV = 17;
  localparam logic [26:0] VEC [NV] = '{
    {4'd0, 21'h1FFFFF, 1'b0, 1'b1}, {4'd0, 21'h000000, 1'b1, 1'b1},
    {4'd1, 21'h1F0000, 1'b0, 1'b0}, {4'd1, 21'h1EFFFF, 1'b0, 1'b1},
    {4'd1, 21'h000000, 1'b1, 1'b0},
    {4'd2, 21'h1E0000, 1'b0, 1'b0}, {4'd2, 21'h1DFFFF, 1'b0, 1'b1},
    {4'd3, 21'h1C0000, 1'b0, 1'b0}, {4'd3, 21'h1BFFFF, 1'b0, 1'b1},
    {4'd4, 21'h180000, 1'b0, 1'b0}, {4'd4, 21'h17FFFF, 1'b0, 1'b1},
    {4'd5, 21'h100000, 1'b0, 1'b0}, {4'd5, 21'h0FFFFF, 1'b0, 1'b1},
    {4'd6, 21'h000000, 1'b0, 1'b0}, {4'd7, 21'h000123, 1'b0, 1'b0},
    {4'd8, 21'h1FFFFF, 1'b0, 1'b1}, {4'd8, 21'h000000, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] c);
    @(negedge clk); op_valid = 1'b1; op_code = c;
    @(negedge clk); op_valid = 1'b0;
  endtask

  task automatic dat(input logic [7:0] d);
    @(negedge clk); data_valid = 1'b1; data_byte = d;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic frame_end();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] arm, input logic [7:0] d);
    op(arm); frame_end();
    op(8'h01); dat(d); frame_end();
  endtask

  task automatic engine(input logic s, input logic a, input logic d);
    @(negedge clk); op_start = s; aai_start = a; op_done = d;
    @(negedge clk); op_start = 1'b0; aai_start = 1'b0; op_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", status, 8'h1C);

    op(8'h06); check("R2 wren", status, 8'h1E);
    op(8'h04); check("R2 wrdi", status, 8'h1C);

    for (int i = 0; i < NV; i++) begin
      sr_write(8'h50, {2'b00, VEC[i][26:23], 2'b00});
      check("R4 table write", status, {2'b00, VEC[i][26:23], 2'b00});
      req_addr = VEC[i][22:2]; req_chip = VEC[i][1];
      #1;
      check(VEC[i][1] ? "R7 chip permit" : "R6 addr permit", {7'd0, permit}, {7'd0, VEC[i][0]});
    end
    req_chip = 1'b0;

    op(8'h01); dat(8'h00); frame_end();
    check("R3 unarmed", status, 8'h20);
    op(8'h50); op(8'h05); op(8'h01); dat(8'h00); frame_end();
    check("R3 arming cancelled", status, 8'h20);
    op(8'h06); check("R2 wren arm", status, 8'h22);
    op(8'h01); dat(8'h00); frame_end();
    check("R3 R4 wren-armed write", status, 8'h00);

    sr_write(8'h50, 8'hFF); check("R4 ro bits", status, 8'hBC);
    sr_write(8'h50, 8'h00); check("R5 wp high lock ignored", status, 8'h00);

    wp_n = 1'b0;
    sr_write(8'h50, 8'h88); check("R5 set lock with bp", status, 8'h88);
    sr_write(8'h50, 8'h00); check("R5 locked refused", status, 8'h88);
    wp_n = 1'b1;
    sr_write(8'h50, 8'h00); check("R5 unlock wp high", status, 8'h00);

    op(8'h50); frame_end(); op(8'h01); frame_end(); dat(8'h10); frame_end();
    check("R10 early cs cancels", status, 8'h00);

    op(8'h06);
    engine(1'b1, 1'b0, 1'b0); check("R8 busy set", status, 8'h03);
    engine(1'b0, 1'b0, 1'b1); check("R8 done clears", status, 8'h00);
    op(8'h06);
    engine(1'b1, 1'b1, 1'b0); check("R8 aai busy", status, 8'h43);
    engine(1'b0, 1'b0, 1'b1); check("R8 aai keeps wel", status, 8'h42);
    op(8'h04); check("R2 wrdi clears aai", status, 8'h00);

    op(8'h06);
    engine(1'b1, 1'b0, 1'b0);
    op(8'h04); check("R9 wrdi refused busy", status, 8'h03);
    sr_write(8'h50, 8'h3C); check("R9 write refused busy", status, 8'h03);
    engine(1'b0, 1'b0, 1'b1); check("R9 after done", status, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule